// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides, for each incoming Ethernet frame, whether the frame is kept or dropped, based only on its 48-bit destination address. The address arrives one byte per cycle, in wire order, each byte qualified by a valid strobe, with a start flag on the first byte. One cycle after the sixth byte is taken, the block emits a one-cycle decision strobe with an accept flag.

The decision follows a fixed priority. Promiscuous mode keeps everything. Otherwise the all-ones address is a broadcast, and it is kept unless broadcast blocking is set. Otherwise an address with the group bit set is a multicast, and it is kept when one bit of a 64-entry hash table is set. That bit is chosen by the top six bits of a reflected CRC-32 of the six address bytes. Any other address is a unicast, and it is kept only on an exact match with the station address. Station address, hash table and mode flags are static inputs that the surrounding receive logic holds steady.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: A unicast address (bit 0 of byte 0 is 0) equal in all 48 bits to the station address is accepted when promiscuous mode is off.
- R2: A unicast address that differs from the station address in any single bit is rejected when promiscuous mode is off.
- R3: The all-ones address is accepted when `bcast_block` is 0, whatever the hash table holds.
- R4: The all-ones address is rejected when `bcast_block` is 1 and promiscuous mode is off, even with every hash table bit set.
- R5: With `promisc_en` at 1, every address is accepted, including broadcast with `bcast_block` at 1.
- R6: A non-broadcast address with bit 0 of byte 0 set is accepted exactly when the table bit at index crc[31:26] is 1. The CRC is computed over the six bytes in wire order, with polynomial 0xEDB88320, LSB first, preset to all ones and no final inversion. Index bit 5 set selects `mc_hash_hi`, and index bit 5 clear selects `mc_hash_lo`. Index bits [4:0] give the bit position inside that word.
- R7: Both hash words all ones accept every multicast address, and both all zeros reject every multicast address.
- R8: `dec_vld` is high for exactly one cycle, the cycle after the sixth address byte is taken. At no other time is it high, and `dec_accept` is 0 whenever `dec_vld` is 0.
- R9: Cycles with `da_vld` low are skipped inside an address. Bytes that arrive while no address is open (no preceding `da_first`) are ignored and produce no decision. A byte with `da_first` high restarts the address at byte 0.
- R10: The station address is little-endian. `stn_lo[7:0]` is the first byte on the wire, `stn_lo[31:24]` is byte 3, and `stn_hi[15:8]` is byte 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| da_vld | input | 1 | Address byte valid |
| da_first | input | 1 | Marks the first byte of an address (with `da_vld`) |
| da_byte | input | 8 | Address byte, wire order |
| stn_lo | input | 32 | Station address bytes 0 to 3 |
| stn_hi | input | 16 | Station address bytes 4 and 5 |
| mc_hash_lo | input | 32 | Hash table entries 0 to 31 |
| mc_hash_hi | input | 32 | Hash table entries 32 to 63 |
| promisc_en | input | 1 | Accept every frame |
| bcast_block | input | 1 | Reject broadcast frames |
| dec_vld | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted (valid with `dec_vld`) |

## Verification
The bench builds the filter with its default parameters: six address bytes, a six-bit hash index and the hash lookup variant enabled. At these values the full 64-entry table, split into two 32-bit words, is reachable. A sweep of multicast addresses under single-bit tables lands on indices in both words, so the word select and the bit select are both exercised against a CRC model written in the bench. The broadcast-before-hash priority is visible because broadcast blocking is tested with a full table.

// File: rtl/eth_filt_pkg.sv
`timescale 1ns/1ps
package eth_filt_pkg;
   localparam int unsigned OCTET_W  = 8;
   localparam int unsigned CRC_W    = 32;
   localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB8_8320;
   localparam logic [CRC_W-1:0] CRC_PRESET    = '1;

   typedef enum logic [1:0] {
      DA_UNICAST   = 2'd0,
      DA_MULTICAST = 2'd1,
      DA_BROADCAST = 2'd2
   } da_kind_e;

   // Reflected CRC over one octet, least significant bit first.
   function automatic logic [CRC_W-1:0] crc_octet(
      input logic [CRC_W-1:0]   crc_in,
      input logic [OCTET_W-1:0] octet,
      input logic [CRC_W-1:0]   poly);
      logic [CRC_W-1:0] r;
      r = crc_in ^ {{(CRC_W-OCTET_W){1'b0}}, octet};
      for (int b = 0; b < OCTET_W; b++) begin
         r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
      end
      return r;
   endfunction
endpackage

// File: rtl/efilt_collect.sv
`timescale 1ns/1ps
module efilt_collect
   import eth_filt_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 6,
   parameter logic [31:0] POLY       = CRC_POLY_REFL
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_vld,
   input  logic                          in_first,
   input  logic [OCTET_W-1:0]            in_byte,
   output logic [ADDR_BYTES*OCTET_W-1:0] addr_q,
   output logic [CRC_W-1:0]              crc_q,
   output logic                          done_q
);
   localparam int unsigned ADDR_W = ADDR_BYTES * OCTET_W;
   localparam int unsigned CNT_W  = $clog2(ADDR_BYTES + 1);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   // Number of bytes already taken; zero means no address is open.
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         addr_q <= '0;
         crc_q  <= CRC_PRESET;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (in_vld && in_first) begin
            addr_q <= {{(ADDR_W-OCTET_W){1'b0}}, in_byte};
            crc_q  <= crc_octet(CRC_PRESET, in_byte, POLY);
            cnt_q  <= ONE;
         end else if (in_vld && (cnt_q != '0)) begin
            addr_q[int'(cnt_q)*OCTET_W +: OCTET_W] <= in_byte;
            crc_q <= crc_octet(crc_q, in_byte, POLY);
            if (cnt_q == LAST_IDX) begin
               cnt_q  <= '0;
               done_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + ONE;
            end
         end
      end
   end
endmodule

// File: rtl/efilt_decide.sv
`timescale 1ns/1ps
module efilt_decide
   import eth_filt_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned HASH_IDX_W = 6,
   parameter bit          HASH_EN    = 1'b1
) (
   input  logic [ADDR_BYTES*OCTET_W-1:0] addr,
   input  logic [CRC_W-1:0]              crc,
   input  logic [ADDR_BYTES*OCTET_W-1:0] station,
   input  logic [(1<<HASH_IDX_W)-1:0]    hash_tbl,
   input  logic                          promisc,
   input  logic                          bcast_off,
   output da_kind_e                      kind,
   output logic                          accept
);
   logic [HASH_IDX_W-1:0] hash_idx;
   logic                  hash_hit;
   logic                  exact_hit;

   assign hash_idx  = crc[CRC_W-1 -: HASH_IDX_W];
   assign exact_hit = (addr == station);

   generate
      if (HASH_EN) begin : g_hash
         assign hash_hit = hash_tbl[hash_idx];
      end else begin : g_no_hash
         logic unused_hash;
         assign unused_hash = ^{hash_tbl, hash_idx};
         assign hash_hit    = 1'b0;
      end
   endgenerate

   always_comb begin
      if (&addr)        kind = DA_BROADCAST;
      else if (addr[0]) kind = DA_MULTICAST;
      else              kind = DA_UNICAST;
   end

   always_comb begin
      if (promisc) begin
         accept = 1'b1;
      end else begin
         unique case (kind)
            DA_BROADCAST: accept = !bcast_off;
            DA_MULTICAST: accept = hash_hit;
            default:      accept = exact_hit;
         endcase
      end
   end
endmodule

// File: rtl/eth_rx_addr_filter.sv
`timescale 1ns/1ps
module eth_rx_addr_filter
   import eth_filt_pkg::*;
#(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned HASH_IDX_W = 6,
   parameter bit          HASH_EN    = 1'b1,
   parameter logic [31:0] CRC_POLY   = CRC_POLY_REFL
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              da_vld,
   input  logic                              da_first,
   input  logic [7:0]                        da_byte,
   input  logic [31:0]                       stn_lo,
   input  logic [ADDR_BYTES*8-33:0]          stn_hi,
   input  logic [(1<<HASH_IDX_W)/2-1:0]      mc_hash_lo,
   input  logic [(1<<HASH_IDX_W)/2-1:0]      mc_hash_hi,
   input  logic                              promisc_en,
   input  logic                              bcast_block,
   output logic                              dec_vld,
   output logic                              dec_accept
);
   localparam int unsigned ADDR_W = ADDR_BYTES * OCTET_W;
   localparam int unsigned TBL_W  = 1 << HASH_IDX_W;

   generate
      if (ADDR_BYTES < 5 || ADDR_BYTES > 8) begin : g_bad_bytes
         $error("ADDR_BYTES must lie between 5 and 8");
      end
      if (HASH_IDX_W < 1 || HASH_IDX_W > 10) begin : g_bad_idx
         $error("HASH_IDX_W must lie between 1 and 10");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   logic [CRC_W-1:0]  crc_q;
   logic              done_q;
   logic              acc_c;
   da_kind_e          kind_c;
   logic [TBL_W-1:0]  tbl;
   logic [ADDR_W-1:0] station;

   assign tbl     = {mc_hash_hi, mc_hash_lo};
   assign station = {stn_hi, stn_lo};

   efilt_collect #(.ADDR_BYTES(ADDR_BYTES), .POLY(CRC_POLY)) u_collect (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (da_vld),
      .in_first (da_first),
      .in_byte  (da_byte),
      .addr_q   (addr_q),
      .crc_q    (crc_q),
      .done_q   (done_q)
   );

   efilt_decide #(.ADDR_BYTES(ADDR_BYTES), .HASH_IDX_W(HASH_IDX_W), .HASH_EN(HASH_EN)) u_decide (
      .addr      (addr_q),
      .crc       (crc_q),
      .station   (station),
      .hash_tbl  (tbl),
      .promisc   (promisc_en),
      .bcast_off (bcast_block),
      .kind      (kind_c),
      .accept    (acc_c)
   );

   logic unused_kind;
   assign unused_kind = ^kind_c;

   assign dec_vld    = done_q;
   assign dec_accept = done_q & acc_c;
endmodule

// File: rtl/efilt_chk.sv
`timescale 1ns/1ps
module efilt_chk #(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned WORD_W     = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              da_vld,
   input logic              da_first,
   input logic [7:0]        da_byte,
   input logic [WORD_W-1:0] mc_hash_lo,
   input logic [WORD_W-1:0] mc_hash_hi,
   input logic              promisc_en,
   input logic              bcast_block,
   input logic              dec_vld,
   input logic              dec_accept
);
   localparam int unsigned CW = $clog2(ADDR_BYTES + 1);
   localparam logic [CW-1:0] LASTB = CW'(ADDR_BYTES - 1);

   logic [CW-1:0] ck_cnt;
   logic          ck_allff;
   logic          ck_group;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_cnt   <= '0;
         ck_allff <= 1'b0;
         ck_group <= 1'b0;
      end else if (da_vld && da_first) begin
         ck_cnt   <= CW'(1);
         ck_allff <= (da_byte == 8'hFF);
         ck_group <= da_byte[0];
      end else if (da_vld && ck_cnt != '0) begin
         ck_allff <= ck_allff && (da_byte == 8'hFF);
         ck_cnt   <= (ck_cnt == LASTB) ? '0 : ck_cnt + CW'(1);
      end
   end

   // R8: decision one cycle after the last byte
   a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (da_vld && !da_first && ck_cnt == LASTB) |=> dec_vld);
   a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |=> !dec_vld);
   a_r8_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld |-> $past(da_vld));
   a_r8_quiet_accept: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_vld |-> !dec_accept);
   // R3, R4, R5: broadcast and promiscuous handling
   a_r3_bcast_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && !bcast_block && ck_allff) |-> dec_accept);
   a_r4_bcast_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && bcast_block && !promisc_en && ck_allff) |-> !dec_accept);
   a_r5_promisc: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && promisc_en) |-> dec_accept);
   // R7: a full table keeps every multicast
   a_r7_all_mcast: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_vld && ck_group && !ck_allff && (&mc_hash_lo) && (&mc_hash_hi)) |-> dec_accept);
endmodule

bind eth_rx_addr_filter efilt_chk #(
   .ADDR_BYTES (ADDR_BYTES),
   .WORD_W     ((1 << HASH_IDX_W) / 2)
) u_efilt_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .da_vld      (da_vld),
   .da_first    (da_first),
   .da_byte     (da_byte),
   .mc_hash_lo  (mc_hash_lo),
   .mc_hash_hi  (mc_hash_hi),
   .promisc_en  (promisc_en),
   .bcast_block (bcast_block),
   .dec_vld     (dec_vld),
   .dec_accept  (dec_accept)
);

// File: tb/test_eth_rx_addr_filter.sv
`timescale 1ns/1ps
module test_eth_rx_addr_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        da_vld = 1'b0, da_first = 1'b0;
   logic [7:0]  da_byte = '0;
   logic [31:0] stn_lo;
   logic [15:0] stn_hi;
   logic [31:0] mc_hash_lo = '0, mc_hash_hi = '0;
   logic        promisc_en = 1'b0, bcast_block = 1'b0;
   logic        dec_vld, dec_accept;

   int unsigned total = 0, bad = 0, cyc = 0, pulses = 0;
   bit          finished = 1'b0;

   int unsigned q_cyc[$];
   bit          q_acc[$];
   string       q_tag[$];

   localparam logic [47:0] STATION = 48'h5544_3322_1102;

   always #10 clk = ~clk;

   eth_rx_addr_filter i_eth_rx_addr_filter (
      .clk(clk), .rst_n(rst_n), .da_vld(da_vld), .da_first(da_first), .da_byte(da_byte),
      .stn_lo(stn_lo), .stn_hi(stn_hi), .mc_hash_lo(mc_hash_lo), .mc_hash_hi(mc_hash_hi),
      .promisc_en(promisc_en), .bcast_block(bcast_block),
      .dec_vld(dec_vld), .dec_accept(dec_accept));

   assign stn_lo = STATION[31:0];
   assign stn_hi = STATION[47:32];

   always @(posedge clk) cyc <= cyc + 1;

   // Bench CRC: bit-serial form of the reflected CRC-32 (R6)
   function automatic logic [5:0] hash_index(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < 48; i++) begin
         logic fb = c[0] ^ a[i];
         c = c >> 1;
         if (fb) c = c ^ 32'hEDB8_8320;
      end
      return c[31:26];
   endfunction

   function automatic bit model(input logic [47:0] a);
      logic [5:0] ix;
      if (promisc_en) return 1'b1;
      if (a == '1) return !bcast_block;
      if (a[0]) begin
         ix = hash_index(a);
         return ix[5] ? mc_hash_hi[ix[4:0]] : mc_hash_lo[ix[4:0]];
      end
      return a == STATION;
   endfunction

   task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Driver: sends one address, pushes the expected result.
   task automatic send(input logic [47:0] a, input string tag, input bit gaps);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         da_vld = 1'b1; da_first = (i == 0); da_byte = a[8*i +: 8];
         if (i == 5) begin
            q_cyc.push_back(cyc + 1);
            q_acc.push_back(model(a));
            q_tag.push_back(tag);
         end else if (gaps) begin
            @(negedge clk);
            da_vld = 1'b0; da_first = 1'b0; da_byte = 8'hA5;
         end
      end
      @(negedge clk); da_vld = 1'b0; da_first = 1'b0;
      @(negedge clk);
   endtask

   // Monitor: pops expected decisions as the design produces them.
   always @(posedge clk) begin
      #15;
      if (rst_n && dec_vld) begin
         pulses++;
         if (q_acc.size() == 0) begin
            check(1'b0, "R8/R9", "unexpected decision", 1, 0);
         end else begin
            automatic int unsigned ec = q_cyc.pop_front();
            automatic bit ea = q_acc.pop_front();
            automatic string tg = q_tag.pop_front();
            check(cyc == ec, "R8", {"decision cycle for ", tg}, cyc, ec);
            check(dec_accept == ea, tg, "accept", dec_accept, ea);
         end
      end
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         bad++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", total + 1, bad);
         $finish;
      end
   end

   initial begin
      int unsigned p0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(dec_vld == 1'b0 && dec_accept == 1'b0, "R8", "reset outputs", {dec_vld, dec_accept}, 0);

      // R1, R10: exact station match, byte order
      send(STATION, "R1", 1'b0);
      send(48'h0255_4433_2211, "R10", 1'b0);
      send(48'h0211_2233_4455, "R10", 1'b0);
      // R2: one bit off, first and last byte
      send(STATION ^ 48'h8000_0000_0000, "R2", 1'b0);
      send(STATION ^ 48'h0000_0000_0002, "R2", 1'b0);
      send(STATION ^ 48'h0000_0100_0000, "R2", 1'b0);
      // R3, R4: broadcast, blocked even with a full table
      send('1, "R3", 1'b0);
      mc_hash_lo = '1; mc_hash_hi = '1;
      send('1, "R3", 1'b0);
      bcast_block = 1'b1;
      send('1, "R4", 1'b0);
      mc_hash_lo = '0; mc_hash_hi = '0;
      send('1, "R4", 1'b0);
      // R5: promiscuous
      promisc_en = 1'b1;
      send('1, "R5", 1'b0);
      send(48'h0BAD_CAFE_0000, "R5", 1'b0);
      send(48'h0100_0000_5E01, "R5", 1'b0);
      promisc_en = 1'b0; bcast_block = 1'b0;
      // R6: single-bit tables, hit, complement, neighbour
      for (int k = 0; k < 16; k++) begin
         automatic logic [47:0] a = {8'(k * 17), 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01};
         automatic logic [5:0] ix = hash_index(a);
         automatic logic [63:0] t = 64'd1 << ix;
         {mc_hash_hi, mc_hash_lo} = t;
         send(a, ix[5] ? "R6 hi" : "R6 lo", 1'b0);
         {mc_hash_hi, mc_hash_lo} = ~t;
         send(a, "R6", 1'b0);
         {mc_hash_hi, mc_hash_lo} = 64'd1 << (ix ^ 6'd1);
         send(a, "R6", 1'b0);
      end
      // R7: all ones and all zeros
      mc_hash_lo = '1; mc_hash_hi = '1;
      send(48'h0000_0000_0033, "R7", 1'b0);
      send(48'h1234_5678_9AB1, "R7", 1'b0);
      mc_hash_lo = '0; mc_hash_hi = '0;
      send(48'h0000_0000_0033, "R7", 1'b0);
      send(48'h1234_5678_9AB1, "R7", 1'b0);
      // R9: gaps inside an address
      send(STATION, "R9", 1'b1);
      // R9: bytes with no open address produce nothing
      p0 = pulses;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); da_vld = 1'b1; da_first = 1'b0; da_byte = STATION[8*i +: 8];
      end
      @(negedge clk); da_vld = 1'b0;
      repeat (3) @(negedge clk);
      check(pulses == p0, "R9", "decisions without start", pulses - p0, 0);
      // R9: restart midway
      p0 = pulses;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); da_vld = 1'b1; da_first = (i == 0); da_byte = 8'h77;
      end
      send(STATION, "R9", 1'b0);
      check(pulses - p0 == 1, "R9", "decisions after restart", pulses - p0, 1);

      repeat (4) @(negedge clk);
      check(q_acc.size() == 0, "R8", "missing decisions", q_acc.size(), 0);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule